// File: doc/BRIEF.md
# APB Window Decoder with Error Sink

This block sits between an APB requester and four subordinates. It compares the address of the current transfer against four fixed, size-aligned windows and raises one select line for the subordinate that owns the address. It then steers that subordinate's read data, ready and error back to the requester. Addresses that fall in no window are taken by a built-in sink. The sink finishes the transfer at once with an error and an all-zero read value, so the transfer neither hangs nor returns undriven data.

The decoder is purely combinational and acts on the address the requester presents in the same cycle. It also produces a per-subordinate write strobe, which is only valid in the access phase of a write. It provides a word index of the register inside a window for the subordinates to use. The window layout is set by parameters. If the layout is misaligned, has a size that is not a power of two, or has windows that overlap, elaboration stops with an error.

Top module: `apb_window_decoder`

## Requirements
- R1: With psel high, an address inside the window of subordinate i (bases 0x000, 0x100, 0x200, 0x300, each 0x100 bytes) raises bit i of subSel and no other select.
- R2: All 32 address bits are compared. An address with any bit from 10 to 31 set (for example 0x1200 or 0x8000_0300) selects no subordinate and goes to the sink.
- R3: Window edges come only from the masks: 0x0FF selects 0, 0x100 selects 1, 0x1FF selects 1, 0x200 selects 2, 0x3FF selects 3, and 0x400 selects the sink.
- R4: While psel is high, exactly one of subSel[3:0] and sinkSel is high.
- R5: While psel is low, subSel, sinkSel, subWrEn, prdata, pready and pslverr are all zero.
- R6: subWrEn[i] is high exactly when subSel[i], penable and pwrite are all high.
- R7: When the sink is selected, pready and pslverr equal penable, and prdata is 0.
- R8: When subordinate i is selected, prdata, pready and pslverr equal that subordinate's own rdata slice (bits 32*i+31 down to 32*i), ready bit and error bit.
- R9: regIndex equals paddr[7:2], which is the word index inside a 256-byte window.
- R10: The select follows the address in the same cycle. When a new transfer follows the previous one with no idle cycle, the select for the new address shows in the new transfer's setup cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, used by the embedded checks |
| presetn | input | 1 | Active-low bus reset, used by the embedded checks |
| paddr | input | 32 | Byte address of the current transfer |
| psel | input | 1 | Requester select for the bridge |
| penable | input | 1 | Access-phase indicator |
| pwrite | input | 1 | Write direction |
| subRdata | input | 128 | Read data of all subordinates, subordinate i at bits 32*i+31:32*i |
| subReady | input | 4 | Ready from each subordinate |
| subSlvErr | input | 4 | Error from each subordinate |
| subSel | output | 4 | One-hot subordinate select |
| sinkSel | output | 1 | Sink select for unmapped addresses |
| subWrEn | output | 4 | Access-phase write strobe per subordinate |
| regIndex | output | 6 | Word index inside the window |
| prdata | output | 32 | Read data returned to the requester |
| pready | output | 1 | Ready returned to the requester |
| pslverr | output | 1 | Error returned to the requester |

## Verification
The bench walks the first byte, the last byte and the first byte past each window. A decoder with an inclusive bound would raise two selects at 0x100 or 0x200, and one with an off-by-one mask would open a one-byte hole. It also probes mirror addresses such as 0x1200 and high-bit addresses. A decoder that compares only the low byte would let a subordinate answer there instead of the sink. Back-to-back transfers with no idle cycle expose a decoder that acts on a registered address, because that decoder selects the previous target. Byte-stride random addresses catch a register index taken from the wrong bits. Idle cycles with random response inputs catch selects or response data that leak while psel is low.

// File: rtl/apb_dec_pkg.sv
package apb_dec_pkg;

  // Strobes that the decode control hands to the response datapath.
  typedef struct packed {
    logic anyHit;       // some subordinate window matched
    logic sinkHit;      // psel high and no window matched
    logic accessPhase;  // psel && penable
  } decStrobe_t;

  function automatic logic isPow2(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

endpackage

// File: rtl/decode_ctrl.sv
module decode_ctrl
  import apb_dec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SUB    = 4,
  parameter int OFFSET_MSB = 7,
  parameter logic [NUM_SUB-1:0][ADDR_W-1:0] BASES = '0,
  parameter logic [NUM_SUB-1:0][ADDR_W-1:0] SIZES = '0
) (
  input  logic                    pclk,
  input  logic                    presetn,
  input  logic [ADDR_W-1:0]       paddr,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  output logic [NUM_SUB-1:0]      subSel,
  output logic [NUM_SUB-1:0]      subWrEn,
  output logic [OFFSET_MSB-2:0]   regIndex,
  output decStrobe_t              strobes
);

  logic [NUM_SUB-1:0] winHit;

  // One masked equality compare per window; all address bits take part.
  for (genvar i = 0; i < NUM_SUB; i++) begin : gWin
    localparam logic [ADDR_W-1:0] MASK = SIZES[i] - 1'b1;

    if (!isPow2(32'(SIZES[i]))) begin : gBadSize
      $error("window %0d size is not a power of two", i);
    end
    if ((BASES[i] & MASK) != '0) begin : gBadAlign
      $error("window %0d base is not aligned to its size", i);
    end
    for (genvar j = i + 1; j < NUM_SUB; j++) begin : gPair
      localparam logic [ADDR_W-1:0] MASKJ = SIZES[j] - 1'b1;
      if (((BASES[i] ^ BASES[j]) & ~(MASK | MASKJ)) == '0) begin : gOverlap
        $error("windows %0d and %0d intersect", i, j);
      end
    end

    assign winHit[i] = ((paddr & ~MASK) == BASES[i]);
  end

  assign subSel   = psel ? winHit : '0;
  assign subWrEn  = (psel && penable && pwrite) ? winHit : '0;
  assign regIndex = paddr[OFFSET_MSB:2];

  always_comb begin
    strobes.anyHit      = psel && (winHit != '0);
    strobes.sinkHit     = psel && (winHit == '0);
    strobes.accessPhase = psel && penable;
  end

  AST_SEL_ONEHOT: assert property (@(posedge pclk) disable iff (!presetn)
    psel |-> $onehot({strobes.sinkHit, subSel})); // R4

  AST_IDLE_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    !psel |-> (subSel == '0 && subWrEn == '0 && !strobes.sinkHit)); // R5

  AST_WREN_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    (subWrEn != '0) |-> (penable && pwrite && (subWrEn == subSel))); // R6

  AST_SINK_NO_WREN: assert property (@(posedge pclk) disable iff (!presetn)
    strobes.sinkHit |-> (subWrEn == '0)); // R7

endmodule

// File: rtl/resp_mux.sv
module resp_mux
  import apb_dec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SUB = 4
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic [NUM_SUB-1:0]          subSel,
  input  decStrobe_t                  strobes,
  input  logic [NUM_SUB*DATA_W-1:0]   subRdata,
  input  logic [NUM_SUB-1:0]          subReady,
  input  logic [NUM_SUB-1:0]          subSlvErr,
  output logic [DATA_W-1:0]           prdata,
  output logic                        pready,
  output logic                        pslverr
);

  // AND-OR steering: an all-zero select vector yields zeros.
  always_comb begin
    logic [DATA_W-1:0] dataAcc;
    dataAcc = '0;
    for (int i = 0; i < NUM_SUB; i++) begin
      dataAcc |= {DATA_W{subSel[i]}} & subRdata[i*DATA_W +: DATA_W];
    end
    prdata = dataAcc;  // sink contributes zero data
  end

  assign pready  = (|(subSel & subReady))  | (strobes.sinkHit && strobes.accessPhase);
  assign pslverr = (|(subSel & subSlvErr)) | (strobes.sinkHit && strobes.accessPhase);

  AST_SINK_ERROR: assert property (@(posedge pclk) disable iff (!presetn)
    (strobes.sinkHit && strobes.accessPhase) |-> (pready && pslverr && prdata == '0)); // R7

  AST_NOSEL_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (!strobes.anyHit && !strobes.sinkHit) |-> (prdata == '0 && !pready && !pslverr)); // R5

  AST_SINK_SETUP: assert property (@(posedge pclk) disable iff (!presetn)
    (strobes.sinkHit && !strobes.accessPhase) |-> (!pready && !pslverr)); // R7

endmodule

// File: rtl/apb_window_decoder.sv
module apb_window_decoder
  import apb_dec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_SUB    = 4,
  parameter int OFFSET_MSB = 7,
  parameter logic [NUM_SUB-1:0][ADDR_W-1:0] BASES =
    {32'h0000_0300, 32'h0000_0200, 32'h0000_0100, 32'h0000_0000},
  parameter logic [NUM_SUB-1:0][ADDR_W-1:0] SIZES =
    {32'h0000_0100, 32'h0000_0100, 32'h0000_0100, 32'h0000_0100}
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [NUM_SUB*DATA_W-1:0]   subRdata,
  input  logic [NUM_SUB-1:0]          subReady,
  input  logic [NUM_SUB-1:0]          subSlvErr,
  output logic [NUM_SUB-1:0]          subSel,
  output logic                        sinkSel,
  output logic [NUM_SUB-1:0]          subWrEn,
  output logic [OFFSET_MSB-2:0]       regIndex,
  output logic [DATA_W-1:0]           prdata,
  output logic                        pready,
  output logic                        pslverr
);

  decStrobe_t strobes;

  decode_ctrl #(
    .ADDR_W(ADDR_W), .NUM_SUB(NUM_SUB), .OFFSET_MSB(OFFSET_MSB),
    .BASES(BASES), .SIZES(SIZES)
  ) u_ctrl (
    .pclk(pclk), .presetn(presetn),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
    .subSel(subSel), .subWrEn(subWrEn), .regIndex(regIndex),
    .strobes(strobes)
  );

  resp_mux #(
    .DATA_W(DATA_W), .NUM_SUB(NUM_SUB)
  ) u_resp (
    .pclk(pclk), .presetn(presetn),
    .subSel(subSel), .strobes(strobes),
    .subRdata(subRdata), .subReady(subReady), .subSlvErr(subSlvErr),
    .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  assign sinkSel = strobes.sinkHit;

endmodule

// File: tb/apb_window_decoder_tb.sv
module apb_window_decoder_tb;

  logic         pclk = 1'b0;
  logic         presetn = 1'b0;
  logic [31:0]  paddr = '0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [127:0] subRdata = '0;
  logic [3:0]   subReady = '0, subSlvErr = '0;
  logic [3:0]   subSel, subWrEn;
  logic         sinkSel, pready, pslverr;
  logic [5:0]   regIndex;
  logic [31:0]  prdata;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #10 pclk = ~pclk;  // 50 MHz

  apb_window_decoder u_dut (
    .pclk(pclk), .presetn(presetn), .paddr(paddr), .psel(psel),
    .penable(penable), .pwrite(pwrite), .subRdata(subRdata),
    .subReady(subReady), .subSlvErr(subSlvErr), .subSel(subSel),
    .sinkSel(sinkSel), .subWrEn(subWrEn), .regIndex(regIndex),
    .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  // Reference model from the requirements.
  function automatic logic [3:0] expSel(input logic [31:0] a, input logic s);
    if (!s || a[31:10] != '0) return 4'b0;
    return 4'b0001 << a[9:8];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual=%0h expected=%0h (addr=%08h)", req, act, exp, paddr);
    end
  endtask

  task automatic checkAll(input string req);
    logic [3:0]  es;
    logic        ed, er, ee;
    logic [31:0] eData;
    es = expSel(paddr, psel);
    ed = psel && (es == 4'b0);
    eData = '0; er = 1'b0; ee = 1'b0;
    for (int i = 0; i < 4; i++) if (es[i]) begin
      eData = subRdata[i*32 +: 32]; er = subReady[i]; ee = subSlvErr[i];
    end
    if (ed) begin er = penable; ee = penable; end
    check({req, " subSel"},   64'(subSel),   64'(es));
    check({req, " sinkSel"},  64'(sinkSel),  64'(ed));
    check({req, " subWrEn R6"}, 64'(subWrEn), 64'((penable && pwrite) ? es : 4'b0));
    check({req, " prdata R8"},  64'(prdata),  64'(eData));
    check({req, " pready R8"},  64'(pready),  64'(er));
    check({req, " pslverr R8"}, 64'(pslverr), 64'(ee));
    check({req, " regIndex R9"}, 64'(regIndex), 64'(paddr[7:2]));
  endtask

  task automatic randResp();
    subRdata  = {$urandom, $urandom, $urandom, $urandom};
    subReady  = 4'($urandom);
    subSlvErr = 4'($urandom);
  endtask

  // Drive on the falling edge, check a quarter period later.
  task automatic drive(input logic [31:0] a, input logic s, input logic en,
                       input logic w, input string req);
    @(negedge pclk);
    paddr = a; psel = s; penable = en; pwrite = w;
    randResp();
    #5;
    checkAll(req);
  endtask

  task automatic transfer(input logic [31:0] a, input logic w, input string req);
    drive(a, 1'b1, 1'b0, w, req);
    drive(a, 1'b1, 1'b1, w, req);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    failCount++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd2024));
    // Reset state / idle: R5
    drive(32'h0000_0100, 1'b0, 1'b0, 1'b0, "R5 idle");
    repeat (2) @(negedge pclk);
    presetn = 1'b1;
    drive(32'h0000_0204, 1'b0, 1'b1, 1'b1, "R5 idle penable");

    // Window interiors: R1
    transfer(32'h0000_0040, 1'b1, "R1 win0");
    transfer(32'h0000_0184, 1'b0, "R1 win1");
    transfer(32'h0000_02A8, 1'b1, "R1 win2");
    transfer(32'h0000_03C0, 1'b0, "R1 win3");

    // Edges: R3
    transfer(32'h0000_00FF, 1'b1, "R3 0x0FF");
    transfer(32'h0000_0100, 1'b1, "R3 0x100");
    transfer(32'h0000_01FF, 1'b0, "R3 0x1FF");
    transfer(32'h0000_0200, 1'b1, "R3 0x200");
    transfer(32'h0000_03FF, 1'b1, "R3 0x3FF");
    transfer(32'h0000_0400, 1'b1, "R3 0x400");

    // Mirrors and high bits: R2, sink response R7
    transfer(32'h0000_1200, 1'b1, "R2 mirror 0x1200");
    transfer(32'h8000_0300, 1'b0, "R2 high bit");
    transfer(32'hFFFF_FFFC, 1'b0, "R7 sink read");

    // Back-to-back with no idle: R10
    transfer(32'h0000_0010, 1'b1, "R10 first");
    transfer(32'h0000_0310, 1'b1, "R10 next");
    transfer(32'h0000_5000, 1'b0, "R10 to sink");
    transfer(32'h0000_0220, 1'b0, "R10 from sink");

    // Constrained random, one transfer then maybe an idle: R4
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      case ($urandom % 4)
        0, 1: a = $urandom % 32'h500;
        2:    a = ($urandom % 32'h400) | (32'h1 << (10 + $urandom % 22));
        default: a = $urandom;
      endcase
      transfer(a, 1'($urandom), "R4 random");
      if ($urandom % 3 == 0)
        drive($urandom, 1'b0, 1'($urandom), 1'($urandom), "R5 random idle");
    end

    @(negedge pclk);
    finish();
  end

endmodule